// File: doc/BRIEF.md
# Indirect-Access Power-of-Two Clock Divider

This block divides several input clocks, each by its own power of two, and sends the divided clocks on to serial channels. Every clock lane has a small exponent setting. A value of 0 passes the input straight through. A value of N gives an output period of 2^N input periods at 50 % duty. The exponent is at most 15, so the deepest ratio is 32768.

The settings sit in a small internal configuration RAM that the host cannot address directly. The host first writes an entry index into an index register at bus offset 0xA0. It then reads or writes that entry through a window register at bus offset 0xA4. A window write changes the entry only when the qualify bit, bit 7 of the written word, is 1. A new exponent reaches the divider only at the end of the current divided period, so the output never shows a shortened pulse.

All logic runs on one system clock. The input clocks are level signals synchronous to it and slower than half its rate. Each lane registers its input once, detects rising edges and counts them.

Top module: `pow2_clkdiv_bank`

## Requirements
- R1: A write to bus offset 0xA0 loads bits [5:0] of the write data into the index register. A read of 0xA0 returns the index in bits [5:0] and zeros in every other bit.
- R2: A write to bus offset 0xA4 with bit 7 set stores write-data bits [3:0] as the exponent of the entry that the index selects. A read of 0xA4 returns that entry's exponent in bits [3:0] and zeros in every other bit, bit 7 included.
- R3: A write to 0xA4 with bit 7 clear leaves every entry unchanged.
- R4: When the index is 4 or more, which selects no lane, a read of 0xA4 returns zero and a write to 0xA4 changes no entry.
- R5: A read of any bus offset other than 0xA0 and 0xA4 returns zero. A write to such an offset changes neither the index nor any entry.
- R6: After reset, every exponent is 0, the index is 0 and every divided output is low.
- R7: With exponent 0, a lane's output copies its input level with a latency of two system clock cycles.
- R8: With exponent N ≥ 1, each output period covers 2^N input rising edges. The output is low for the first 2^(N-1) edges after a period boundary and high for the next 2^(N-1). With the input toggling every cycle, both the high and the low phase last 2^N cycles.
- R9: Exponent 15, the largest, divides by 32768.
- R10: A changed exponent takes effect only at a period boundary. In divided mode the boundary is the input rising edge that ends the high phase. In pass-through every input rising edge is a boundary. The high phase in progress when the change arrives keeps its old length.
- R11: Lanes run independently. A lane's exponent changes the output of that lane only.
- R12: An output changes only two cycles after a change of its own input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register pair |
| bus_addr | input | 8 | Bus byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current bus offset (combinational) |
| src_clk | input | 4 | Input clock levels, one per lane |
| div_clk | output | 4 | Divided clocks, one per lane |

## Verification
The assertions check the register behaviour on every cycle. They cover qualified updates, unqualified and foreign writes that leave state alone, and zero reads of unused entries. They also check the reset state and that no output edge appears without an input edge two cycles earlier. Only the bench scenarios can show the timing of the divided waveform. These cover the exact phase lengths across a sweep of exponents and the full 32768 ratio. They also cover a setting changed mid-period that leaves the running high phase intact, and lanes that run different ratios side by side.

// File: rtl/pow2_clkdiv_pkg.sv
package pow2_clkdiv_pkg;

   // which register of the pair a bus access selects
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_ADDR = 2'd1,
      ACC_DATA = 2'd2
   } acc_e;

endpackage

// File: rtl/pow2_clkdiv_regs.sv
module pow2_clkdiv_regs
   import pow2_clkdiv_pkg::*;
#(
   parameter int NUM_CLK  = 4,
   parameter int EXP_W    = 4,
   parameter int RAM_AW   = 6,
   parameter int BUS_AW   = 8,
   parameter int BUS_DW   = 32,
   parameter logic [BUS_AW-1:0] ADDR_OFS = 8'hA0,
   parameter logic [BUS_AW-1:0] DATA_OFS = 8'hA4,
   parameter int QUAL_BIT = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_wr,
   input  logic [BUS_AW-1:0]          bus_addr,
   input  logic [BUS_DW-1:0]          bus_wdata,
   output logic [BUS_DW-1:0]          bus_rdata,
   output logic [RAM_AW-1:0]          ram_addr,
   output logic [NUM_CLK*EXP_W-1:0]   cfg_flat
);

   acc_e                             acc;
   logic [RAM_AW-1:0]                addr_q;
   logic [NUM_CLK-1:0][EXP_W-1:0]    cfg_q;
   logic [EXP_W-1:0]                 rd_entry;
   logic                             wr_qual;

   always_comb begin
      acc = ACC_NONE;
      if (bus_addr == ADDR_OFS)      acc = ACC_ADDR;
      else if (bus_addr == DATA_OFS) acc = ACC_DATA;
   end

   assign wr_qual = bus_wr && (acc == ACC_DATA) && bus_wdata[QUAL_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            addr_q <= '0;
      else if (bus_wr && (acc == ACC_ADDR))  addr_q <= bus_wdata[RAM_AW-1:0];
   end

   // only indices below NUM_CLK own storage; the rest of the space is empty
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         for (int k = 0; k < NUM_CLK; k++) begin
            if (wr_qual && (addr_q == RAM_AW'(k))) cfg_q[k] <= bus_wdata[EXP_W-1:0];
         end
      end
   end

   always_comb begin
      rd_entry = '0;
      for (int k = 0; k < NUM_CLK; k++) begin
         if (addr_q == RAM_AW'(k)) rd_entry = cfg_q[k];
      end
   end

   always_comb begin
      unique case (acc)
         ACC_ADDR: bus_rdata = BUS_DW'(addr_q);
         ACC_DATA: bus_rdata = BUS_DW'(rd_entry);
         default:  bus_rdata = '0;
      endcase
   end

   assign ram_addr = addr_q;

   genvar g;
   generate
      for (g = 0; g < NUM_CLK; g++) begin : g_flat
         assign cfg_flat[g*EXP_W +: EXP_W] = cfg_q[g];
      end
   endgenerate

endmodule

// File: rtl/pow2_div_lane.sv
module pow2_div_lane #(
   parameter int EXP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_clk,
   input  logic [EXP_W-1:0] exp_cfg,
   output logic             div_clk
);

   localparam int CNT_W = (1 << EXP_W) - 1;

   logic              in_q, in_prev, rise;
   logic [EXP_W-1:0]  act_q, act_n;
   logic [CNT_W-1:0]  cnt_q, cnt_n, lim;
   logic [CNT_W:0]    lim_w;
   logic [CNT_W:0]    cnt_x;
   logic              div_n, div_q;

   assign rise  = in_q & ~in_prev;
   assign lim_w = ({{CNT_W{1'b0}}, 1'b1} << act_q) - {{CNT_W{1'b0}}, 1'b1};
   assign lim   = lim_w[CNT_W-1:0];

   // a period ends on the rising edge that brings the counter back to zero;
   // only there may a new exponent be adopted
   always_comb begin
      act_n = act_q;
      cnt_n = cnt_q;
      if (rise) begin
         if (cnt_q == lim) begin
            act_n = exp_cfg;
            cnt_n = '0;
         end else begin
            cnt_n = cnt_q + CNT_W'(1);
         end
      end
      cnt_x = {1'b0, cnt_n};
      div_n = (act_n == '0) ? in_q : cnt_x[act_n - 1'b1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q    <= 1'b0;
         in_prev <= 1'b0;
         act_q   <= '0;
         cnt_q   <= '0;
         div_q   <= 1'b0;
      end else begin
         in_q    <= src_clk;
         in_prev <= in_q;
         act_q   <= act_n;
         cnt_q   <= cnt_n;
         div_q   <= div_n;
      end
   end

   assign div_clk = div_q;

endmodule

// File: rtl/pow2_clkdiv_bank.sv
module pow2_clkdiv_bank #(
   parameter int NUM_CLK  = 4,
   parameter int EXP_W    = 4,
   parameter int RAM_AW   = 6,
   parameter int BUS_AW   = 8,
   parameter int BUS_DW   = 32,
   parameter logic [BUS_AW-1:0] ADDR_OFS = 8'hA0,
   parameter logic [BUS_AW-1:0] DATA_OFS = 8'hA4,
   parameter int QUAL_BIT = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [BUS_AW-1:0]  bus_addr,
   input  logic [BUS_DW-1:0]  bus_wdata,
   output logic [BUS_DW-1:0]  bus_rdata,
   input  logic [NUM_CLK-1:0] src_clk,
   output logic [NUM_CLK-1:0] div_clk
);

   generate
      if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
         $error("EXP_W must lie in 1..5");
      end
      if (QUAL_BIT < EXP_W || QUAL_BIT >= BUS_DW) begin : g_bad_qual
         $error("QUAL_BIT must sit above the exponent field and inside the bus");
      end
      if (RAM_AW > BUS_DW || NUM_CLK > (1 << RAM_AW) || NUM_CLK < 1) begin : g_bad_ram
         $error("index space must hold every lane and fit the bus");
      end
      if (ADDR_OFS == DATA_OFS) begin : g_bad_ofs
         $error("register offsets must differ");
      end
   endgenerate

   logic [RAM_AW-1:0]        ram_addr;
   logic [NUM_CLK*EXP_W-1:0] cfg_flat;

   pow2_clkdiv_regs #(
      .NUM_CLK (NUM_CLK),
      .EXP_W   (EXP_W),
      .RAM_AW  (RAM_AW),
      .BUS_AW  (BUS_AW),
      .BUS_DW  (BUS_DW),
      .ADDR_OFS(ADDR_OFS),
      .DATA_OFS(DATA_OFS),
      .QUAL_BIT(QUAL_BIT)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .ram_addr (ram_addr),
      .cfg_flat (cfg_flat)
   );

   genvar g;
   generate
      for (g = 0; g < NUM_CLK; g++) begin : g_lane
         pow2_div_lane #(.EXP_W(EXP_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_clk(src_clk[g]),
            .exp_cfg(cfg_flat[g*EXP_W +: EXP_W]),
            .div_clk(div_clk[g])
         );
      end
   endgenerate

endmodule

// File: rtl/pow2_clkdiv_chk.sv
module pow2_clkdiv_chk #(
   parameter int NUM_CLK  = 4,
   parameter int EXP_W    = 4,
   parameter int RAM_AW   = 6,
   parameter int BUS_AW   = 8,
   parameter int BUS_DW   = 32,
   parameter logic [BUS_AW-1:0] ADDR_OFS = 8'hA0,
   parameter logic [BUS_AW-1:0] DATA_OFS = 8'hA4,
   parameter int QUAL_BIT = 7
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     bus_wr,
   input logic [BUS_AW-1:0]        bus_addr,
   input logic [BUS_DW-1:0]        bus_wdata,
   input logic [BUS_DW-1:0]        bus_rdata,
   input logic [NUM_CLK-1:0]       src_clk,
   input logic [NUM_CLK-1:0]       div_clk,
   input logic [RAM_AW-1:0]        ram_addr,
   input logic [NUM_CLK*EXP_W-1:0] cfg_flat
);

   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   p_unqual_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DATA_OFS && !bus_wdata[QUAL_BIT]) |=> $stable(cfg_flat));

   p_unused_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == DATA_OFS && int'(ram_addr) >= NUM_CLK) |-> (bus_rdata == '0));

   p_unused_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DATA_OFS && int'(ram_addr) >= NUM_CLK) |=> $stable(cfg_flat));

   p_foreign_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr != ADDR_OFS && bus_addr != DATA_OFS)
      |=> ($stable(cfg_flat) && $stable(ram_addr)));

   p_reset_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd0) |-> (div_clk == '0 && ram_addr == '0 && cfg_flat == '0));

   genvar g;
   generate
      for (g = 0; g < NUM_CLK; g++) begin : g_chk
         p_legal_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == DATA_OFS && bus_wdata[QUAL_BIT] && ram_addr == RAM_AW'(g))
            |=> (cfg_flat[g*EXP_W +: EXP_W] == $past(bus_wdata[EXP_W-1:0])));

         p_edge_follows_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (age == 2'd3 && div_clk[g] != $past(div_clk[g]))
            |-> ($past(src_clk[g], 2) != $past(src_clk[g], 3)));
      end
   endgenerate

endmodule

bind pow2_clkdiv_bank pow2_clkdiv_chk #(
   .NUM_CLK (NUM_CLK),
   .EXP_W   (EXP_W),
   .RAM_AW  (RAM_AW),
   .BUS_AW  (BUS_AW),
   .BUS_DW  (BUS_DW),
   .ADDR_OFS(ADDR_OFS),
   .DATA_OFS(DATA_OFS),
   .QUAL_BIT(QUAL_BIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .src_clk  (src_clk),
   .div_clk  (div_clk),
   .ram_addr (ram_addr),
   .cfg_flat (cfg_flat)
);

// File: tb/pow2_clkdiv_bank_tb.sv
module pow2_clkdiv_bank_tb;

   localparam logic [7:0] A_IDX = 8'hA0;
   localparam logic [7:0] A_WIN = 8'hA4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  src_clk = '0;
   logic [3:0]  div_clk;
   logic [3:0]  pat = '0;
   logic        tog_en = 1'b0;
   int          n_vec = 0;
   int          n_bad = 0;

   pow2_clkdiv_bank u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .src_clk  (src_clk),
      .div_clk  (div_clk)
   );

   always #4 clk = ~clk;

   always @(posedge clk) begin
      #1;
      if (tog_en) src_clk <= ~src_clk;
      else        src_clk <= pat;
   end

   initial begin
      repeat (195000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b0;
      #1 d = bus_rdata;
   endtask

   task automatic set_exp(input int lane, input int n);
      bus_write(A_IDX, 32'(lane));
      bus_write(A_WIN, 32'h80 | 32'(n));
   endtask

   task automatic wait_fall(input int lane);
      logic prev;
      prev = div_clk[lane];
      for (int g = 0; g < 100000; g++) begin
         @(negedge clk);
         if (prev && !div_clk[lane]) break;
         prev = div_clk[lane];
      end
   endtask

   task automatic measure(input int lane, output int hi, output int lo);
      logic prev;
      prev = div_clk[lane];
      for (int g = 0; g < 100000; g++) begin
         @(negedge clk);
         if (!prev && div_clk[lane]) break;
         prev = div_clk[lane];
      end
      hi = 1;
      for (int g = 0; g < 100000; g++) begin
         @(negedge clk);
         if (div_clk[lane]) hi++; else break;
      end
      lo = 1;
      for (int g = 0; g < 100000; g++) begin
         @(negedge clk);
         if (!div_clk[lane]) lo++; else break;
      end
   endtask

   initial begin
      logic [31:0] rd;
      logic [3:0]  hist [64];
      int hi, lo;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R6: reset state
      @(negedge clk);
      check("R6 outputs low", 32'(div_clk), 32'h0);
      bus_read(A_IDX, rd);
      check("R6 index zero", rd, 32'h0);
      for (int k = 0; k < 4; k++) begin
         bus_write(A_IDX, 32'(k));
         bus_read(A_WIN, rd);
         check("R6 entry zero", rd, 32'h0);
      end

      // R5: foreign offsets
      bus_write(A_IDX, 32'h1);
      bus_read(8'h00, rd);  check("R5 read 0x00", rd, 32'h0);
      bus_read(8'hA8, rd);  check("R5 read 0xA8", rd, 32'h0);
      bus_write(8'hA8, 32'hFFFF_FFFF);
      bus_write(8'hA1, 32'h0000_008F);
      bus_write(8'h24, 32'h0000_00A2);
      bus_read(A_IDX, rd);  check("R5 index kept", rd, 32'h1);
      bus_read(A_WIN, rd);  check("R5 entry kept", rd, 32'h0);

      // R1: index register
      bus_write(A_IDX, 32'h2A);
      bus_read(A_IDX, rd);  check("R1 index 0x2A", rd, 32'h2A);
      bus_write(A_IDX, 32'hFFFF_FFFF);
      bus_read(A_IDX, rd);  check("R1 index masked", rd, 32'h3F);

      // R2: qualified writes, readback format
      for (int k = 0; k < 4; k++) set_exp(k, k * 3 + 2);
      for (int k = 0; k < 4; k++) begin
         bus_write(A_IDX, 32'(k));
         bus_read(A_WIN, rd);
         check("R2 entry readback", rd, 32'(k * 3 + 2));
      end
      bus_write(A_IDX, 32'h0);
      bus_write(A_WIN, 32'hFFFF_FF8D);
      bus_read(A_WIN, rd);  check("R2 only exponent bits", rd, 32'hD);

      // R3: unqualified writes
      bus_write(A_IDX, 32'h1);
      bus_write(A_WIN, 32'h0000_0007);
      bus_read(A_WIN, rd);  check("R3 bit7 clear", rd, 32'h5);
      bus_write(A_WIN, 32'hFFFF_FF7F);
      bus_read(A_WIN, rd);  check("R3 bit7 clear, others set", rd, 32'h5);

      // R4: unused entries
      for (int a = 4; a < 64; a++) begin
         bus_write(A_IDX, 32'(a));
         bus_write(A_WIN, 32'h8F);
         bus_read(A_WIN, rd);
         check("R4 unused reads zero", rd, 32'h0);
      end
      for (int k = 0; k < 4; k++) begin
         bus_write(A_IDX, 32'(k));
         bus_read(A_WIN, rd);
         check("R4 entries untouched", rd, (k == 0) ? 32'hD : 32'(k * 3 + 2));
      end
      check("R4 outputs idle", 32'(div_clk), 32'h0);

      for (int k = 0; k < 4; k++) set_exp(k, 0);

      // R7: pass-through of an irregular pattern, two cycles late
      for (int j = 0; j < 64; j++) begin
         @(negedge clk);
         hist[j] = 4'((j * 13) ^ (j >> 1) ^ (j >> 3));
         if (j >= 3) check("R7 pass-through", 32'(div_clk), 32'(hist[j-3]));
         pat = hist[j];
      end
      @(negedge clk);
      pat = '0;
      tog_en = 1'b1;

      // R8: sweep of exponents on lane 0
      for (int n = 0; n <= 10; n++) begin
         set_exp(0, n);
         wait_fall(0);
         wait_fall(0);
         measure(0, hi, lo);
         check("R8 high phase", 32'(hi), 32'(1 << n));
         check("R8 low phase", 32'(lo), 32'(1 << n));
      end

      // R11: lanes with different ratios side by side
      set_exp(1, 3);
      set_exp(2, 5);
      wait_fall(2); wait_fall(2);
      measure(1, hi, lo);
      check("R11 lane1 high", 32'(hi), 32'd8);
      check("R11 lane1 low", 32'(lo), 32'd8);
      measure(2, hi, lo);
      check("R11 lane2 high", 32'(hi), 32'd32);
      check("R11 lane2 low", 32'(lo), 32'd32);
      measure(0, hi, lo);
      check("R11 lane0 unaffected", 32'(hi), 32'd1024);

      // R10: change during a high phase lands at the period end
      set_exp(1, 10);
      wait_fall(1); wait_fall(1);
      fork
         measure(1, hi, lo);
         begin
            repeat (1300) @(negedge clk);
            set_exp(1, 1);
         end
      join
      check("R10 running high phase kept", 32'(hi), 32'd1024);
      check("R10 new ratio after boundary", 32'(lo), 32'd2);
      measure(1, hi, lo);
      check("R10 new ratio high", 32'(hi), 32'd2);

      // R9: deepest ratio on lane 3 (was pass-through)
      set_exp(3, 15);
      measure(3, hi, lo);
      check("R9 high 32768", 32'(hi), 32'd32768);
      check("R9 low 32768", 32'(lo), 32'd32768);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule